// File: doc/BRIEF.md
# Address-Steered Serial Configuration Port

This block receives configuration words over three wires: a serial clock, a serial data line and a latch enable. While latch enable is low, each rising edge of the serial clock moves one data bit into an 18-bit shift register, most significant bit first. When latch enable then rises, the bit clocked in last acts as an address. It sends the other seventeen bits to one of two holding registers. The holding registers drive the static configuration of a frequency synthesizer core. That core is not part of this block.

Address 1 selects the reference register, which is 14 bits wide. Its fields are a 10-bit reference divide value, a test-mode bit, a reserved bit, a phase-detector polarity bit and a charge-pump tri-state bit. Address 0 selects the 17-bit feedback register, which stores all seventeen data bits without decoding them. Each write raises a one-cycle strobe for the register that was written. A reference write raises a one-cycle error pulse if its divide value is below the legal minimum of 2 or its reserved bit is set. The word is still stored in that case.

All three serial inputs pass through a two-stage synchronizer into the system clock domain. A state machine sequences the transfer. Its states are ST_HOLD (latch enable high, waiting), ST_SHIFT (latch enable low, accepting bits) and ST_LOAD (one transfer cycle). Its transitions are:
- ST_HOLD to ST_SHIFT when the synchronized latch enable is low.
- ST_SHIFT to ST_LOAD when the synchronized latch enable is seen high, that is, on its rising edge.
- ST_LOAD to ST_HOLD unconditionally.

The state machine stays in ST_HOLD while latch enable is high and in ST_SHIFT while it is low.

Top module: `synth_cfg_port`

## Requirements
- R1: After the active-low asynchronous reset, every holding register output is zero, and ref_upd, fb_upd and cfg_err are low.
- R2: While latch enable is low, each rising edge of ser_clk shifts ser_data into bit 0 of the shift register, with older bits moving toward bit 17. The first bit sent ends in bit 17, and the last bit sent (the address) ends in bit 0.
- R3: While latch enable is high, ser_clk edges leave the shift register unchanged. A later latch enable rise with no clocks in between transfers the same word again.
- R4: On a transfer with bit 0 = 1, the reference fields are loaded from the shift register as follows:
  - ref_div from bits 10..1
  - ref_cp_tri from bit 11
  - ref_pol from bit 12
  - ref_rsvd from bit 13
  - ref_test from bit 14

  Bits 17..15 have no effect.
- R5: On a transfer with bit 0 = 0, fb_word is loaded from shift register bits 17..1, with bit 17 landing in fb_word bit 16.
- R6: The holding register that is not addressed keeps its previous contents.
- R7: Each transfer raises exactly one strobe, ref_upd or fb_upd according to the address, for exactly one clock cycle.
- R8: cfg_err pulses for one cycle together with ref_upd when a reference write has ref_div of 0 or 1 or a set reserved bit, and the value is stored anyway. A feedback write never raises cfg_err.
- R9: No transfer and no strobe occur while bits are being shifted. A transfer happens only after a low-to-high change of latch enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch enable; a rising edge transfers the word |
| ref_div | output | 10 | Reference divide value |
| ref_test | output | 1 | Test-mode control bit |
| ref_rsvd | output | 1 | Reserved bit as stored |
| ref_pol | output | 1 | Phase-detector polarity |
| ref_cp_tri | output | 1 | Charge-pump tri-state |
| fb_word | output | 17 | Feedback register contents |
| ref_upd | output | 1 | One-cycle strobe on a reference write |
| fb_upd | output | 1 | One-cycle strobe on a feedback write |
| cfg_err | output | 1 | One-cycle pulse on an illegal reference word |

## Verification
The bench sweeps reference divide values 0 to 63 and 1020 to 1023. It varies the control bits and the don't-care bits along with them, so that each field is shown to come from its own bit position. The low divide values also separate legal words from illegal ones at the minimum. Reference writes are interleaved with feedback writes that carry a walking one, all ones and all zeros. Together these expose any misplaced bit, show that the unaddressed register is kept, and show that only the addressed strobe fires. Serial clock pulses are sent while latch enable is high, followed by a second latch enable rise with no clocks, to show that the shift register is frozen. A strobe counter that runs during shifting shows that no transfer happens early.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOAD  = 2'd2
    } load_state_e;
endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VEC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= {STAGES{RST_VEC[b]}};
            else        pipe <= {pipe[STAGES-2:0], d[b]};
        end
        assign q[b] = pipe[STAGES-1];
    end
endmodule

// File: rtl/synth_cfg_shifter.sv
module synth_cfg_shifter #(
    parameter int SR_W = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_s,
    input  logic            sdata_s,
    input  logic            le_s,
    output logic [SR_W-1:0] sr
);
    logic sclk_q;
    logic shift_en;

    assign shift_en = sclk_s & ~sclk_q & ~le_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            sr     <= '0;
        end else begin
            sclk_q <= sclk_s;
            if (shift_en) sr <= {sr[SR_W-2:0], sdata_s};
        end
    end

    // R3: frozen while latch enable is high
    assert_shift_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        le_s |=> $stable(sr));

    // R2: new bit enters at bit 0, older bits move up
    assert_shift_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_s && !sclk_q && !le_s) |=>
            (sr[0] == $past(sdata_s)) && (sr[SR_W-1:1] == $past(sr[SR_W-2:0])));
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
    import synth_cfg_pkg::*;
#(
    parameter int DIV_W   = 10,
    parameter int FB_W    = 17,
    parameter int MIN_DIV = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 le_s,
    input  logic [FB_W:0]        sr,
    output logic [DIV_W+3:0]     ref_q,
    output logic [FB_W-1:0]      fb_q,
    output logic                 ref_upd,
    output logic                 fb_upd,
    output logic                 cfg_err
);
    localparam int REF_W    = DIV_W + 4;
    localparam int RSVD_BIT = DIV_W + 2;
    localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);

    load_state_e state, state_nx;

    logic             addr_in;
    logic [REF_W-1:0] ref_in;
    logic             ref_bad;

    assign addr_in = sr[0];
    assign ref_in  = sr[REF_W:1];
    assign ref_bad = (ref_in[DIV_W-1:0] < MIN_V) | ref_in[RSVD_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HOLD:  if (!le_s) state_nx = ST_SHIFT;
            ST_SHIFT: if (le_s)  state_nx = ST_LOAD;
            ST_LOAD:             state_nx = ST_HOLD;
            default:             state_nx = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q   <= '0;
            fb_q    <= '0;
            ref_upd <= 1'b0;
            fb_upd  <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            ref_upd <= 1'b0;
            fb_upd  <= 1'b0;
            cfg_err <= 1'b0;
            if (state == ST_LOAD) begin
                if (addr_in) begin
                    ref_q   <= ref_in;
                    ref_upd <= 1'b1;
                    cfg_err <= ref_bad;
                end else begin
                    fb_q   <= sr[FB_W:1];
                    fb_upd <= 1'b1;
                end
            end
        end
    end

    // R9: load state entered only from shifting
    assert_load_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |-> ($past(state) == ST_SHIFT));

    // R7: strobes exclusive and single-cycle
    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_upd && fb_upd));
    assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_upd || fb_upd) |=> !(ref_upd || fb_upd));

    // R6: a register changes only together with its strobe
    assert_ref_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_q) |-> ref_upd);
    assert_fb_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fb_q) |-> fb_upd);

    // R8: error tied to an illegal stored reference word
    assert_err_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> ref_upd);
    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_upd && ((ref_q[DIV_W-1:0] < MIN_V) || ref_q[RSVD_BIT])) |-> cfg_err);
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port #(
    parameter int DIV_W       = 10,
    parameter int FB_W        = 17,
    parameter int MIN_DIV     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_le,
    output logic [DIV_W-1:0] ref_div,
    output logic             ref_test,
    output logic             ref_rsvd,
    output logic             ref_pol,
    output logic             ref_cp_tri,
    output logic [FB_W-1:0]  fb_word,
    output logic             ref_upd,
    output logic             fb_upd,
    output logic             cfg_err
);
    localparam int SR_W  = FB_W + 1;
    localparam int REF_W = DIV_W + 4;

    logic [2:0]       sync_q;
    logic [SR_W-1:0]  sr;
    logic [REF_W-1:0] ref_q;

    synth_cfg_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VEC(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({ser_le, ser_data, ser_clk}),
        .q    (sync_q)
    );

    synth_cfg_shifter #(.SR_W(SR_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (sync_q[0]),
        .sdata_s(sync_q[1]),
        .le_s   (sync_q[2]),
        .sr     (sr)
    );

    synth_cfg_loader #(
        .DIV_W  (DIV_W),
        .FB_W   (FB_W),
        .MIN_DIV(MIN_DIV)
    ) u_load (
        .clk    (clk),
        .rst_n  (rst_n),
        .le_s   (sync_q[2]),
        .sr     (sr),
        .ref_q  (ref_q),
        .fb_q   (fb_word),
        .ref_upd(ref_upd),
        .fb_upd (fb_upd),
        .cfg_err(cfg_err)
    );

    assign ref_div    = ref_q[DIV_W-1:0];
    assign ref_cp_tri = ref_q[DIV_W];
    assign ref_pol    = ref_q[DIV_W+1];
    assign ref_rsvd   = ref_q[DIV_W+2];
    assign ref_test   = ref_q[DIV_W+3];
endmodule

// File: tb/synth_cfg_port_tb.sv
module synth_cfg_port_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_le = 1'b1;
    logic [9:0]  ref_div;
    logic        ref_test, ref_rsvd, ref_pol, ref_cp_tri;
    logic [16:0] fb_word;
    logic        ref_upd, fb_upd, cfg_err;

    int tests = 0;
    int fails = 0;
    int rcnt = 0, fcnt = 0, ecnt = 0;
    bit done = 1'b0;
    logic [13:0] exp_ref = '0;
    logic [16:0] exp_fb = '0;
    logic [17:0] last_w = '0;

    always #2 clk = ~clk;

    synth_cfg_port dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .ref_div(ref_div), .ref_test(ref_test),
        .ref_rsvd(ref_rsvd), .ref_pol(ref_pol), .ref_cp_tri(ref_cp_tri),
        .fb_word(fb_word), .ref_upd(ref_upd), .fb_upd(fb_upd), .cfg_err(cfg_err)
    );

    always @(negedge clk) begin
        rcnt <= rcnt + int'(ref_upd);
        fcnt <= fcnt + int'(fb_upd);
        ecnt <= ecnt + int'(cfg_err);
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic zero_counts();
        @(posedge clk);
        rcnt = 0; fcnt = 0; ecnt = 0;
    endtask

    task automatic verify(input logic [17:0] w);
        bit addr;
        bit bad;
        addr = w[0];
        bad  = addr && ((w[10:1] < 10'd2) || w[13]);
        if (addr) exp_ref = w[14:1];
        else      exp_fb  = w[17:1];
        chk(ref_div == exp_ref[9:0], "R4 ref_div", 32'(ref_div), 32'(exp_ref[9:0]));
        chk(ref_cp_tri == exp_ref[10], "R4 ref_cp_tri", 32'(ref_cp_tri), 32'(exp_ref[10]));
        chk(ref_pol == exp_ref[11], "R4 ref_pol", 32'(ref_pol), 32'(exp_ref[11]));
        chk(ref_rsvd == exp_ref[12], "R4 ref_rsvd", 32'(ref_rsvd), 32'(exp_ref[12]));
        chk(ref_test == exp_ref[13], "R4 ref_test", 32'(ref_test), 32'(exp_ref[13]));
        chk(fb_word == exp_fb, addr ? "R6 fb kept" : "R5 fb_word",
            32'(fb_word), 32'(exp_fb));
        chk(rcnt == int'(addr), "R7 ref_upd count", 32'(rcnt), 32'(addr));
        chk(fcnt == int'(!addr), "R7 fb_upd count", 32'(fcnt), 32'(!addr));
        chk(ecnt == int'(bad), "R8 cfg_err count", 32'(ecnt), 32'(bad));
    endtask

    task automatic load(input logic [17:0] w);
        zero_counts();
        ser_le = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 17; i >= 0; i--) begin
            ser_data = w[i];
            repeat (2) @(negedge clk);
            ser_clk = 1'b1;
            repeat (2) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (3) @(negedge clk);
        #1;
        chk((rcnt + fcnt) == 0, "R9 no strobe while shifting", 32'(rcnt + fcnt), 32'd0);
        ser_le = 1'b1;
        repeat (10) @(negedge clk);
        #1;
        last_w = w;
        verify(w);
    endtask

    task automatic relatch_after_noise();
        for (int i = 0; i < 6; i++) begin
            ser_data = ~last_w[i];
            repeat (2) @(negedge clk);
            ser_clk = 1'b1;
            repeat (2) @(negedge clk);
            ser_clk = 1'b0;
        end
        zero_counts();
        ser_le = 1'b0;
        repeat (6) @(negedge clk);
        ser_le = 1'b1;
        repeat (10) @(negedge clk);
        #1;
        // R3: the same word is transferred again
        verify(last_w);
    endtask

    function automatic logic [17:0] ref_word(input int d);
        logic [9:0] div;
        div = 10'(d);
        return {3'(d * 5), div[0], 1'(d % 7 == 3), div[1], div[2], div, 1'b1};
    endfunction

    initial begin
        for (int c = 0; c < 190000; c++) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        chk(ref_div == 0 && !ref_test && !ref_rsvd && !ref_pol && !ref_cp_tri,
            "R1 ref reset", 32'(dut_i.ref_div), 32'd0);
        chk(fb_word == 0, "R1 fb reset", 32'(fb_word), 32'd0);
        chk(!ref_upd && !fb_upd && !cfg_err, "R1 strobes reset",
            32'({ref_upd, fb_upd, cfg_err}), 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        for (int d = 0; d < 64; d++) begin
            load(ref_word(d));
            if (d % 4 == 1) load({17'(1 << (d % 17)), 1'b0});
        end
        load({17'h1FFFF, 1'b0});
        load({17'h00000, 1'b0});
        for (int d = 1020; d < 1024; d++) load(ref_word(d));
        load({3'b111, 4'b0000, 10'd500, 1'b1});
        load({3'b000, 4'b0000, 10'd500, 1'b1});
        relatch_after_noise();
        load({17'h15A5A, 1'b0});
        relatch_after_noise();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule